// File: doc/BRIEF.md
# Descriptor Ring Ownership Engine

The engine is the memory-side half of a network controller. It walks one transmit ring and one receive ring of descriptors kept in shared memory. A descriptor may pass between the host and the engine only through an ownership bit in its flag byte. The engine touches only descriptors that the host has handed over. It writes the outcome of the frame into the descriptor's status word first and clears the ownership bit as its final write.

Each descriptor is four 16-bit words at word offsets 0..3. Offset 0 is the buffer base. Offset 1 carries the flag byte in bits 15:8 and the upper base bits in bits 7:0. Offset 2 holds the buffer length as a negated count with bits 15:12 forced to one. Offset 3 is the transmit status word, or the received message length. A ring starts at the base address given at initialisation. Its entry count is 2^n, where n comes from bits 15:13 of the ring-length word. Descriptor i sits at base + 4*i. The serial side is not part of the engine: frame lengths and error outcomes arrive on input pins.

On a transmit-demand pulse, the engine polls the transmit ring from its own index. It continues until it meets a host-owned descriptor. Each received frame goes into the next owned receive descriptor, and spills into the following ones when the buffer is too small.

Top module: `dring_engine`

## Requirements
- R1: Bits 15:13 of a ring-length word give n, and the ring has 2^n entries. Ring bases are 4-word aligned. The engine's ring index wraps to 0 after entry 2^n-1.
- R2: An init_req pulse loads both ring configurations, resets both ring indices to 0 and drops any pending work.
- R3: After a tx_demand pulse, the engine processes owned transmit descriptors (flag bit 7 = 1) in ring order. It stops at the first host-owned one, which it leaves unwritten, and tx_done pulses once per descriptor it returns.
- R4: tx_fetch pulses once per owned transmit descriptor, with tx_fetch_len = (-word2) mod 4096.
- R5: The transmit flag byte written back keeps bits 1:0 (start and end of packet) and the upper base bits, and clears bit 7. It sets bit 2 from tx_defer_in, bit 3 when tx_retry_in is 1, and bit 4 when tx_retry_in is 2 or 3. tx_status_in is written to offset 3.
- R6: Transmit flag bit 6 (error summary) is set exactly when status bit 10, 11, 12, 14 or 15 is set.
- R7: For each descriptor, the write of offset 1 (ownership release) comes in the cycle right after the write of offset 3.
- R8: A frame that fits one buffer gets offset 3 = its byte length, including CRC. Its flag byte has bits 1 and 0 set, bits 5:2 = rx_frame_err[3:0] (framing, overflow, CRC, buffer), bit 6 = OR of those, and bit 7 clear. rx_done pulses once.
- R9: A frame longer than the buffer capacity ((-word2) mod 4096) fills later owned descriptors. Only the first has bit 1 set. Non-final descriptors get offset 3 = 0 and no error bits. Only the final one gets bit 0, the errors and the total length.
- R10: When the next receive descriptor is host-owned, the frame is dropped, rx_missed pulses, nothing is written and the receive index does not advance.
- R11: A frame that arrives while an earlier frame is still being placed is dropped with an rx_missed pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init_req | input | 1 | Load ring configuration, reset indices |
| tx_ring_addr | input | AW | Transmit ring base word address |
| tx_ring_len | input | 16 | Transmit ring-length word (log2 size in 15:13) |
| rx_ring_addr | input | AW | Receive ring base word address |
| rx_ring_len | input | 16 | Receive ring-length word (log2 size in 15:13) |
| tx_demand | input | 1 | Poll the transmit ring |
| tx_status_in | input | 16 | Transmit status word to write back |
| tx_retry_in | input | 2 | Retry outcome: 0 none, 1 one, 2+ several |
| tx_defer_in | input | 1 | Transmission was deferred |
| rx_frame_valid | input | 1 | A received frame is presented |
| rx_frame_len | input | 12 | Received byte count including CRC |
| rx_frame_err | input | 4 | Framing, overflow, CRC, buffer error |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, same cycle as the address |
| tx_fetch | output | 1 | Owned transmit descriptor taken |
| tx_fetch_len | output | 12 | Its frame length in bytes |
| tx_done | output | 1 | Transmit descriptor returned |
| rx_done | output | 1 | Received frame completed |
| rx_missed | output | 1 | Received frame dropped |
| busy | output | 1 | Engine walking or work pending |

## Verification
Transmit walks are tried on a single clean descriptor, on a run of two, on an erroring descriptor, across the ring wrap and against a host-owned head. Together these separate a stop on ownership from a stop on count, and flag composition from status copying. Receive frames are sized below, exactly at, and well above the 64-byte buffer. These sizes separate single-buffer completion from a three-descriptor spill and expose the boundary where the remaining length equals capacity. Host-owned heads and back-to-back frames show that a drop leaves memory and the index untouched. A re-initialisation with a smaller receive ring shows where wrapping happens.

// File: rtl/dring_pkg.sv
package dring_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_TX_FLAG, S_TX_LEN, S_TX_STAT, S_TX_REL,
    S_RX_FLAG, S_RX_LEN, S_RX_STAT, S_RX_REL
  } eng_state_e;

  localparam int OFS_FLAG = 1;
  localparam int OFS_BLEN = 2;
  localparam int OFS_STAT = 3;
  localparam logic [15:0] TX_ERR_MASK = 16'hDC00;

  // Byte count held in a negated length word (upper nibble ignored).
  function automatic logic [11:0] neg_to_count(input logic [15:0] w);
    return 12'(~w[11:0] + 12'd1);
  endfunction

  function automatic logic tx_err_any(input logic [15:0] st);
    return |(st & TX_ERR_MASK);
  endfunction
endpackage

// File: rtl/dring_index.sv
module dring_index #(
  parameter int LW = 3,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [LW-1:0] log2sz,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] mask;

  always_comb begin
    for (int b = 0; b < IW; b++) mask[b] = (b < int'(log2sz));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clear)  idx <= '0;
    else if (step)   idx <= (idx + IW'(1)) & mask;
  end
endmodule

// File: rtl/dring_flags.sv
module dring_flags
  import dring_pkg::*;
(
  input  logic [1:0]  tx_se,
  input  logic [15:0] tx_status,
  input  logic [1:0]  tx_retry,
  input  logic        tx_defer,
  input  logic        rx_first,
  input  logic        rx_last,
  input  logic [3:0]  rx_err,
  output logic [7:0]  tx_flag,
  output logic [7:0]  rx_flag
);
  logic [3:0] rx_err_fin;

  assign tx_flag = {1'b0, tx_err_any(tx_status), 1'b0, tx_retry[1],
                    tx_retry == 2'b01, tx_defer, tx_se};
  assign rx_err_fin = rx_last ? rx_err : 4'b0;
  assign rx_flag = {1'b0, |rx_err_fin, rx_err_fin, rx_first, rx_last};
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  input  logic [AW-1:0] tx_ring_addr,
  input  logic [15:0]   tx_ring_len,
  input  logic [AW-1:0] rx_ring_addr,
  input  logic [15:0]   rx_ring_len,
  input  logic          tx_demand,
  input  logic [15:0]   tx_status_in,
  input  logic [1:0]    tx_retry_in,
  input  logic          tx_defer_in,
  input  logic          rx_frame_valid,
  input  logic [11:0]   rx_frame_len,
  input  logic [3:0]    rx_frame_err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          tx_fetch,
  output logic [11:0]   tx_fetch_len,
  output logic          tx_done,
  output logic          rx_done,
  output logic          rx_missed,
  output logic          busy
);
  localparam int IW = (1 << LW) - 1;

  eng_state_e    state;
  logic [AW-1:0] tx_base, rx_base;
  logic [LW-1:0] tx_log, rx_log;
  logic          tx_pend, rx_pend;
  logic [11:0]   rx_rem, rx_total;
  logic [3:0]    rx_err_q;
  logic          rx_first, rx_last;
  logic [7:0]    hold_hi;
  logic [1:0]    hold_se;
  logic          miss_q;
  logic [IW-1:0] tx_idx, rx_idx;

  // Named internal events
  logic          tx_step, rx_step, owned, on_tx, frame_accept, frame_clash, ring_miss;
  logic [AW-1:0] tx_desc, rx_desc, cur_desc;
  logic [11:0]   buf_cnt;
  logic [12:0]   buf_cap;
  logic [7:0]    tx_flag, rx_flag;

  assign tx_step  = (state == S_TX_REL);
  assign rx_step  = (state == S_RX_REL);
  assign owned    = mem_rdata[15];
  assign on_tx    = state inside {S_TX_FLAG, S_TX_LEN, S_TX_STAT, S_TX_REL};
  assign tx_desc  = tx_base + AW'({tx_idx, 2'b00});
  assign rx_desc  = rx_base + AW'({rx_idx, 2'b00});
  assign cur_desc = on_tx ? tx_desc : rx_desc;
  assign buf_cnt  = neg_to_count(mem_rdata);
  assign buf_cap  = (buf_cnt == 12'd0) ? 13'd4096 : {1'b0, buf_cnt};
  assign frame_accept = rx_frame_valid && !rx_pend;
  assign frame_clash  = rx_frame_valid && rx_pend;
  assign ring_miss    = (state == S_RX_FLAG) && !owned;

  dring_index #(.LW(LW), .IW(IW)) u_tx_idx (
    .clk(clk), .rst_n(rst_n), .clear(init_req), .step(tx_step),
    .log2sz(tx_log), .idx(tx_idx));

  dring_index #(.LW(LW), .IW(IW)) u_rx_idx (
    .clk(clk), .rst_n(rst_n), .clear(init_req), .step(rx_step),
    .log2sz(rx_log), .idx(rx_idx));

  dring_flags u_flags (
    .tx_se(hold_se), .tx_status(tx_status_in), .tx_retry(tx_retry_in),
    .tx_defer(tx_defer_in), .rx_first(rx_first), .rx_last(rx_last),
    .rx_err(rx_err_q), .tx_flag(tx_flag), .rx_flag(rx_flag));

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc;
    mem_wdata = '0;
    unique case (state)
      S_TX_FLAG, S_RX_FLAG: begin
        mem_en = 1'b1; mem_addr = cur_desc + AW'(OFS_FLAG);
      end
      S_TX_LEN, S_RX_LEN: begin
        mem_en = 1'b1; mem_addr = cur_desc + AW'(OFS_BLEN);
      end
      S_TX_STAT: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_desc + AW'(OFS_STAT);
        mem_wdata = tx_status_in;
      end
      S_RX_STAT: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_desc + AW'(OFS_STAT);
        mem_wdata = rx_last ? {4'b0, rx_total} : 16'h0000;
      end
      S_TX_REL: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_desc + AW'(OFS_FLAG);
        mem_wdata = {tx_flag, hold_hi};
      end
      S_RX_REL: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = cur_desc + AW'(OFS_FLAG);
        mem_wdata = {rx_flag, hold_hi};
      end
      default: ;
    endcase
  end

  assign tx_fetch     = (state == S_TX_LEN);
  assign tx_fetch_len = buf_cnt;
  assign tx_done      = tx_step;
  assign rx_done      = rx_step && rx_last;
  assign rx_missed    = miss_q;
  assign busy         = (state != S_IDLE) || tx_pend || rx_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tx_base <= '0; rx_base <= '0; tx_log <= '0; rx_log <= '0;
      tx_pend <= 1'b0; rx_pend <= 1'b0; miss_q <= 1'b0;
      rx_rem <= '0; rx_total <= '0; rx_err_q <= '0;
      rx_first <= 1'b0; rx_last <= 1'b0; hold_hi <= '0; hold_se <= '0;
    end else if (init_req) begin
      state   <= S_IDLE;
      tx_base <= tx_ring_addr;
      rx_base <= rx_ring_addr;
      tx_log  <= tx_ring_len[15:13];
      rx_log  <= rx_ring_len[15:13];
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      miss_q <= frame_clash || ring_miss;
      if (frame_accept) begin
        rx_pend  <= 1'b1;
        rx_rem   <= rx_frame_len;
        rx_total <= rx_frame_len;
        rx_err_q <= rx_frame_err;
        rx_first <= 1'b1;
      end
      unique case (state)
        S_IDLE:
          if (rx_pend)      state <= S_RX_FLAG;
          else if (tx_pend) state <= S_TX_FLAG;
        S_TX_FLAG:
          if (owned) begin
            hold_hi <= mem_rdata[7:0];
            hold_se <= mem_rdata[9:8];
            state   <= S_TX_LEN;
          end else begin
            tx_pend <= 1'b0;
            state   <= S_IDLE;
          end
        S_TX_LEN:  state <= S_TX_STAT;
        S_TX_STAT: state <= S_TX_REL;
        S_TX_REL:  state <= S_IDLE;
        S_RX_FLAG:
          if (owned) begin
            hold_hi <= mem_rdata[7:0];
            state   <= S_RX_LEN;
          end else begin
            rx_pend <= 1'b0;
            state   <= S_IDLE;
          end
        S_RX_LEN: begin
          if ({1'b0, rx_rem} > buf_cap) begin
            rx_last <= 1'b0;
            rx_rem  <= rx_rem - buf_cnt;
          end else begin
            rx_last <= 1'b1;
          end
          state <= S_RX_STAT;
        end
        S_RX_STAT: state <= S_RX_REL;
        S_RX_REL:
          if (rx_last) begin
            rx_pend <= 1'b0;
            state   <= S_IDLE;
          end else begin
            rx_first <= 1'b0;
            state    <= S_RX_FLAG;
          end
        default: state <= S_IDLE;
      endcase
      if (tx_demand) tx_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dring_engine_chk.sv
module dring_engine_chk #(
  parameter int AW = 16,
  parameter int LW = 3,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          tx_done,
  input logic          rx_done,
  input logic          tx_fetch,
  input logic [IW-1:0] tx_idx,
  input logic [LW-1:0] tx_log
);
  AST_RELEASE_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_addr[1:0] == 2'd1) |->
      ($past(mem_en && mem_we) && $past(mem_addr) == mem_addr + AW'(2))); // R7

  AST_TX_RETURN_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (mem_we && !mem_wdata[15])); // R3

  AST_TX_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (mem_wdata[14] == |($past(mem_wdata) & 16'hDC00))); // R6

  AST_RX_FINAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (mem_wdata[14] == |mem_wdata[13:10] && mem_wdata[8] && !mem_wdata[15])); // R8

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, rx_done, tx_fetch})); // R3

  AST_TX_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(tx_idx) >> tx_log) == 0)); // R1
endmodule

bind dring_engine dring_engine_chk #(.AW(AW), .LW(LW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_done(tx_done),
  .rx_done(rx_done), .tx_fetch(tx_fetch), .tx_idx(tx_idx), .tx_log(tx_log));

// File: tb/tb_dring_engine.sv
module tb_dring_engine;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        init_req = 0, tx_demand = 0, tx_defer_in = 0, rx_frame_valid = 0;
  logic [15:0] tx_ring_addr = 16'h0100, rx_ring_addr = 16'h0200;
  logic [15:0] tx_ring_len = 16'h4000, rx_ring_len = 16'h4000;
  logic [15:0] tx_status_in = 0;
  logic [1:0]  tx_retry_in = 0;
  logic [11:0] rx_frame_len = 0;
  logic [3:0]  rx_frame_err = 0;
  logic        mem_en, mem_we, tx_fetch, tx_done, rx_done, rx_missed, busy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [11:0] tx_fetch_len;

  logic [15:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  dring_engine dut (.*);

  int n_chk = 0, n_fail = 0, n_txd = 0, n_rxd = 0, n_miss = 0;
  bit finished = 0;
  int exp_len[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock reference: event counts and expected fetch lengths in ring order
  always @(negedge clk) begin
    if (tx_done) n_txd++;
    if (rx_done) n_rxd++;
    if (rx_missed) n_miss++;
    if (tx_fetch) begin
      if (exp_len.size() == 0) check("R3 unexpected fetch", 1, 0);
      else check("R4 fetch length", int'(tx_fetch_len), exp_len.pop_front());
    end
  end

  function automatic logic [15:0] negw(int n);
    return 16'hF000 | 16'((-n) & 'hFFF);
  endfunction
  function automatic int txa(int i); return 'h100 + 4 * i; endfunction
  function automatic int rxa(int i); return 'h200 + 4 * i; endfunction

  task automatic arm_tx(int i, int len);
    mem[txa(i) + 1] = 16'h8312;
    mem[txa(i) + 2] = negw(len);
    mem[txa(i) + 3] = 16'h0000;
    exp_len.push_back(len);
  endtask
  task automatic arm_rx(int i);
    mem[rxa(i) + 1] = 16'h8034;
    mem[rxa(i) + 2] = negw(64);
    mem[rxa(i) + 3] = 16'hFFFF;
  endtask
  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic demand(logic [15:0] st, logic [1:0] rt, logic df);
    tx_status_in = st; tx_retry_in = rt; tx_defer_in = df;
    tx_demand = 1; @(negedge clk); tx_demand = 0;
    wait_idle();
  endtask
  task automatic frame(int len, logic [3:0] err);
    rx_frame_len = 12'(len); rx_frame_err = err; rx_frame_valid = 1;
    @(negedge clk); rx_frame_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset busy", busy, 0);
    check("R2 reset events", {tx_done, rx_done, rx_missed, mem_en}, 0);
    init_req = 1; @(negedge clk); init_req = 0; @(negedge clk);

    // Transmit: two owned, third host-owned
    arm_tx(0, 100); arm_tx(1, 40);
    demand(16'h0005, 2'd1, 1'b0);
    check("R3 two returned", n_txd, 2);
    check("R5 desc0 flag", mem[txa(0) + 1], 16'h0B12);
    check("R5 desc1 status", mem[txa(1) + 3], 16'h0005);
    check("R3 desc2 untouched", mem[txa(2) + 1], 16'h0000);
    // Erroring descriptor
    arm_tx(2, 60);
    demand(16'h4800, 2'd2, 1'b1);
    check("R6 error flag", mem[txa(2) + 1], 16'h5712);
    check("R5 error status", mem[txa(2) + 3], 16'h4800);
    // Wrap 3 -> 0
    arm_tx(3, 70); arm_tx(0, 61);
    demand(16'h0000, 2'd0, 1'b0);
    check("R1 wrap desc3", mem[txa(3) + 1], 16'h0312);
    check("R1 wrap desc0", mem[txa(0) + 1], 16'h0312);
    check("R3 count after wrap", n_txd, 5);
    // Host-owned head: nothing happens
    demand(16'h0000, 2'd0, 1'b0);
    check("R3 no return", n_txd, 5);
    check("R3 head unchanged", mem[txa(1) + 1], 16'h0B12);
    check("R4 queue drained", exp_len.size(), 0);

    // Receive
    for (int i = 0; i < 4; i++) arm_rx(i);
    frame(60, 4'b0000); wait_idle();
    check("R8 single flag", mem[rxa(0) + 1], 16'h0334);
    check("R8 single length", mem[rxa(0) + 3], 60);
    frame(50, 4'b0010); wait_idle();
    check("R8 crc flag", mem[rxa(1) + 1], 16'h4B34);
    check("R8 rx count", n_rxd, 2);
    arm_rx(0);
    frame(150, 4'b1000); wait_idle();
    check("R9 first part flag", mem[rxa(2) + 1], 16'h0234);
    check("R9 first part len", mem[rxa(2) + 3], 0);
    check("R9 middle flag", mem[rxa(3) + 1], 16'h0034);
    check("R9 final flag", mem[rxa(0) + 1], 16'h6134);
    check("R9 final len", mem[rxa(0) + 3], 150);
    check("R9 one event", n_rxd, 3);
    // Host-owned head
    frame(40, 4'b0000); wait_idle();
    check("R10 missed", n_miss, 1);
    check("R10 desc untouched", mem[rxa(1) + 3], 50);
    arm_rx(1);
    frame(64, 4'b0000); wait_idle();
    check("R10 index kept", mem[rxa(1) + 1], 16'h0334);
    check("R9 exact fit len", mem[rxa(1) + 3], 64);
    // Overlapping frames
    arm_rx(2);
    frame(61, 4'b0000); frame(99, 4'b0000); wait_idle();
    check("R11 missed", n_miss, 2);
    check("R11 first kept", mem[rxa(2) + 3], 61);
    check("R11 next untouched", mem[rxa(3) + 1], 16'h0034);
    check("R11 one event", n_rxd, 5);

    // Re-init with a 2-entry receive ring
    rx_ring_len = 16'h2000;
    init_req = 1; @(negedge clk); init_req = 0; @(negedge clk);
    arm_tx(0, 80);
    demand(16'h0000, 2'd0, 1'b0);
    check("R2 tx index reset", mem[txa(0) + 1], 16'h0312);
    arm_rx(0); arm_rx(1);
    frame(60, 4'b0000); wait_idle();
    frame(61, 4'b0000); wait_idle();
    arm_rx(0);
    frame(62, 4'b0000); wait_idle();
    check("R2 rx index reset", mem[rxa(1) + 3], 61);
    check("R1 small ring wrap", mem[rxa(0) + 3], 62);
    check("R1 beyond ring untouched", mem[rxa(2) + 3], 61);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule